// File: doc/BRIEF.md
# Digital Pattern Generator with Replay

This block drives a small port of digital lines from a queue of stored samples. The host pushes samples into an internal FIFO through a simple write strobe. A separate sample clock comes in from outside the block; the block has no divider of its own. Each active edge of that clock moves the next queued sample onto the lines. The host picks whether rising or falling edges are active. The sample clock input is asynchronous to the system clock. It passes through a two-stage synchronizer, and an edge detector turns it into a one-cycle strobe. An inverted copy of the raw sample clock is also passed out, so it can be forwarded to a terminal.

In replay mode the stored samples are not consumed. The read position loops over the loaded data in the same order for as long as replay stays on. While replay is on, writes are refused. In normal mode, an active edge that finds the FIFO empty sets a sticky underflow flag. The host clears it with a clear strobe, and the waveform lines keep their last value.

Every line has its own two-bit mode. It can be an input (output enable off), a static output driven from a host register bit, or a waveform output driven from the FIFO. The registered state of every pin is readable as a status word.

Top module: `pgen_top`

## Requirements
- R1: Out of reset, `fill_level` is 0, `underflow` is 0, `pin_in_q` is 0 and the waveform value is 0.
- R2: A write with `wr_en` high is accepted only when `fill_level` is below DEPTH and `replay_en` is low; each accepted write raises `fill_level` by one. A write into a full FIFO is dropped and never appears on the lines.
- R3: In normal mode, each active sample-clock edge presents the oldest unread sample, in write order, on every waveform line and lowers `fill_level` by one. The lines update within five system clock cycles of the edge.
- R4: `edge_sel` = 0 makes rising edges of `smp_clk` active; `edge_sel` = 1 makes falling edges active. An edge of the other direction leaves the lines unchanged.
- R5: With `replay_en` high and N samples loaded, successive active edges present samples 1..N, then 1..N again, indefinitely. `fill_level` stays at N.
- R6: While `replay_en` is high, writes are refused and `fill_level` does not change.
- R7: In normal mode, an active edge that finds `fill_level` at 0 sets `underflow`. It stays set until `uf_clr` is pulsed, and the waveform lines hold their last value.
- R8: The mode field `line_mode[2i+1:2i]` selects the mode of line i. 00 = input (`pin_oe[i]`=0, `pin_out[i]`=0). 01 = static (`pin_oe[i]`=1, `pin_out[i]`=`static_val[i]`). 10 = waveform (`pin_oe[i]`=1, `pin_out[i]`= current sample bit i). 11 acts as input.
- R9: `pin_in_q` equals `pin_in` delayed by one system clock register.
- R10: `clk_fwd` is always the inverse of `smp_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host sample write strobe |
| wr_data | input | W | Sample to store |
| replay_en | input | 1 | Loop stored samples instead of consuming them |
| edge_sel | input | 1 | 0 rising, 1 falling active sample edge |
| smp_clk | input | 1 | External sample clock, asynchronous |
| uf_clr | input | 1 | Clears the underflow flag |
| line_mode | input | 2*W | Two-bit mode per line |
| static_val | input | W | Values for static-output lines |
| pin_in | input | W | Pin levels seen at the pads |
| pin_out | output | W | Pad output values |
| pin_oe | output | W | Pad output enables |
| pin_in_q | output | W | Registered pin levels for the host |
| fill_level | output | $clog2(DEPTH+1) | Samples held in the FIFO |
| underflow | output | 1 | Sticky underflow flag |
| clk_fwd | output | 1 | Inverted sample clock for forwarding |

## Verification
The bench runs a short ascending write burst through normal mode to confirm write order and the one-per-edge consumption. It then pushes a burst one longer than the depth, which shows whether the surplus write was dropped or overwrote something. Rising and falling half-pulses are applied separately under each edge setting, which separates correct edge selection from double-stepping. Replay is swept over every load count from one to DEPTH, for more than two full loops each. This separates a correct wrap point from an off-by-one wrap, and a loop from a drain. Every line is then put through all four mode codes against all static words, and all input levels are checked, which catches a swapped mode decode or a crossed bit.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    typedef enum logic [1:0] {
        LM_INPUT  = 2'b00,
        LM_STATIC = 2'b01,
        LM_WAVE   = 2'b10,
        LM_RSVD   = 2'b11
    } line_mode_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    // Pick the pad drive of one line from its mode and both data sources.
    function automatic pin_drive_t resolve_line(line_mode_e m, logic stat_bit, logic wave_bit);
        pin_drive_t d;
        case (m)
            LM_STATIC: begin d.oe = 1'b1; d.val = stat_bit; end
            LM_WAVE:   begin d.oe = 1'b1; d.val = wave_bit; end
            default:   begin d.oe = 1'b0; d.val = 1'b0;     end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pgen_edge_det.sv
module pgen_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    input  logic fall_sel,
    output logic strobe
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        if (fall_sel) strobe = prev_q & ~sync_q;
        else          strobe = sync_q & ~prev_q;
    end
endmodule

// File: rtl/pgen_sample_fifo.sv
module pgen_sample_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         replay,
    input  logic                         rd_stb,
    output logic [W-1:0]                 wave_q,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         empty_hit
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, loop_off;
    logic          is_empty, is_full, do_wr, do_pop, do_loop;

    assign is_empty  = (fill == '0);
    assign is_full   = (fill == CW'(DEPTH));
    assign do_wr     = wr_en && !replay && !is_full;
    assign do_pop    = rd_stb && !replay && !is_empty;
    assign do_loop   = rd_stb && replay && !is_empty;
    assign empty_hit = rd_stb && is_empty;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            loop_off <= '0;
            fill     <= '0;
            wave_q   <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop) begin
                wave_q <= mem[rd_ptr];
                rd_ptr <= rd_ptr + AW'(1);
            end
            if (do_loop) begin
                wave_q <= mem[rd_ptr + loop_off];
                if (CW'(loop_off) + CW'(1) == fill) loop_off <= '0;
                else                                loop_off <= loop_off + AW'(1);
            end
            if (!replay) loop_off <= '0;
            case ({do_wr, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/pgen_line_mux.sv
module pgen_line_mux
    import pgen_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2*W-1:0] line_mode,
    input  logic [W-1:0]   static_val,
    input  logic [W-1:0]   wave_val,
    output logic [W-1:0]   pin_out,
    output logic [W-1:0]   pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_line
        pin_drive_t drv;
        always_comb begin
            drv        = resolve_line(line_mode_e'(line_mode[2*i +: 2]), static_val[i], wave_val[i]);
            pin_out[i] = drv.val;
            pin_oe[i]  = drv.oe;
        end
    end
endmodule

// File: rtl/pgen_top.sv
module pgen_top #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       replay_en,
    input  logic                       edge_sel,
    input  logic                       smp_clk,
    input  logic                       uf_clr,
    input  logic [2*W-1:0]             line_mode,
    input  logic [W-1:0]               static_val,
    input  logic [W-1:0]               pin_in,
    output logic [W-1:0]               pin_out,
    output logic [W-1:0]               pin_oe,
    output logic [W-1:0]               pin_in_q,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic                       underflow,
    output logic                       clk_fwd
);
    logic         rd_stb;
    logic         empty_hit;
    logic [W-1:0] wave_q;

    pgen_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (smp_clk),
        .fall_sel (edge_sel),
        .strobe   (rd_stb)
    );

    pgen_sample_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .replay    (replay_en),
        .rd_stb    (rd_stb),
        .wave_q    (wave_q),
        .fill      (fill_level),
        .empty_hit (empty_hit)
    );

    pgen_line_mux #(.W(W)) u_mux (
        .line_mode  (line_mode),
        .static_val (static_val),
        .wave_val   (wave_q),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            underflow <= 1'b0;
            pin_in_q  <= '0;
        end else begin
            pin_in_q <= pin_in;
            if (empty_hit)   underflow <= 1'b1;
            else if (uf_clr) underflow <= 1'b0;
        end
    end

    assign clk_fwd = ~smp_clk;
endmodule

// File: rtl/pgen_checker.sv
module pgen_checker #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       uf_clr,
    input logic                       replay_en,
    input logic                       smp_clk,
    input logic                       clk_fwd,
    input logic                       underflow,
    input logic                       rd_stb,
    input logic [W-1:0]               wave_q,
    input logic [2*W-1:0]             line_mode,
    input logic [W-1:0]               pin_oe,
    input logic [$clog2(DEPTH+1)-1:0] fill_level
);
    // R7
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && !uf_clr) |=> underflow);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_level <= ($clog2(DEPTH+1))'(DEPTH));

    // R5
    replay_fill_chk: assert property (@(posedge clk) disable iff (rst)
        $past(replay_en) |-> $stable(fill_level));

    // R3
    wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(wave_q));

    // R10
    fwd_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        clk_fwd != smp_clk);

    for (genvar i = 0; i < W; i++) begin : g_oe
        // R8
        input_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
            (line_mode[2*i +: 2] == 2'b00 || line_mode[2*i +: 2] == 2'b11) |-> !pin_oe[i]);
    end
endmodule

bind pgen_top pgen_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .uf_clr     (uf_clr),
    .replay_en  (replay_en),
    .smp_clk    (smp_clk),
    .clk_fwd    (clk_fwd),
    .underflow  (underflow),
    .rd_stb     (rd_stb),
    .wave_q     (wave_q),
    .line_mode  (line_mode),
    .pin_oe     (pin_oe),
    .fill_level (fill_level)
);

// File: tb/pgen_top_bench.sv
module pgen_top_bench;
    localparam int W  = 4;
    localparam int DP = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [W-1:0]   wr_data = '0;
    logic           replay_en = 1'b0;
    logic           edge_sel = 1'b0;
    logic           smp_clk = 1'b0;
    logic           uf_clr = 1'b0;
    logic [2*W-1:0] line_mode = '0;
    logic [W-1:0]   static_val = '0;
    logic [W-1:0]   pin_in = '0;
    logic [W-1:0]   pin_out, pin_oe, pin_in_q;
    logic [2:0]     fill_level;
    logic           underflow, clk_fwd;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pgen_top #(.W(W), .DEPTH(DP)) u_pgen_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .replay_en(replay_en), .edge_sel(edge_sel), .smp_clk(smp_clk),
        .uf_clr(uf_clr), .line_mode(line_mode), .static_val(static_val),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_in_q(pin_in_q), .fill_level(fill_level),
        .underflow(underflow), .clk_fwd(clk_fwd)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        replay_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input int v);
        @(negedge clk) begin wr_en = 1'b1; wr_data = W'(v); end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic half_pulse();
        @(negedge clk) smp_clk = ~smp_clk;
        repeat (6) @(negedge clk);
    endtask

    task automatic full_pulse();
        half_pulse();
        half_pulse();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int vals[4];
        do_reset();
        // R1 reset state
        chk("R1 fill", int'(fill_level), 0);
        chk("R1 underflow", int'(underflow), 0);
        chk("R1 pin_in_q", int'(pin_in_q), 0);
        line_mode = 8'b10101010;
        @(negedge clk);
        chk("R1 wave zero", int'(pin_out), 0);
        chk("R10 low", int'(clk_fwd), 1);

        // R3 normal order
        vals = '{5, 10, 3, 0};
        for (int k = 0; k < 3; k++) push(vals[k]);
        chk("R2 fill after 3", int'(fill_level), 3);
        for (int k = 0; k < 3; k++) begin
            full_pulse();
            chk("R3 sample", int'(pin_out), vals[k]);
            chk("R3 fill", int'(fill_level), 2 - k);
        end

        // R7 underflow
        full_pulse();
        chk("R7 set", int'(underflow), 1);
        chk("R7 hold value", int'(pin_out), 3);
        repeat (10) @(negedge clk);
        chk("R7 sticky", int'(underflow), 1);
        @(negedge clk) uf_clr = 1'b1;
        @(negedge clk) uf_clr = 1'b0;
        chk("R7 cleared", int'(underflow), 0);

        // R2 full rejection
        for (int k = 1; k <= 5; k++) push(k);
        chk("R2 full", int'(fill_level), DP);
        for (int k = 1; k <= 4; k++) begin
            full_pulse();
            chk("R2 drain", int'(pin_out), k);
        end
        chk("R2 empty", int'(fill_level), 0);
        chk("R2 no underflow", int'(underflow), 0);

        // R4 edge select
        push(9); push(6);
        edge_sel = 1'b1;
        half_pulse();
        chk("R4 rise ignored in fall mode", int'(pin_out), 4);
        chk("R10 high", int'(clk_fwd), 0);
        half_pulse();
        chk("R4 fall active", int'(pin_out), 9);
        edge_sel = 1'b0;
        half_pulse();
        chk("R4 rise active", int'(pin_out), 6);
        half_pulse();
        chk("R4 fall ignored in rise mode", int'(pin_out), 6);

        // R5 / R6 replay sweep over load counts
        for (int n = 1; n <= DP; n++) begin
            do_reset();
            for (int j = 0; j < n; j++) push((3 * j + n) & 15);
            @(negedge clk) replay_en = 1'b1;
            push(15);
            chk("R6 write refused", int'(fill_level), n);
            for (int k = 0; k < 2 * n + 2; k++) begin
                full_pulse();
                chk("R5 loop sample", int'(pin_out), (3 * (k % n) + n) & 15);
                chk("R5 fill kept", int'(fill_level), n);
            end
            chk("R5 no underflow", int'(underflow), 0);
            @(negedge clk) replay_en = 1'b0;
        end

        // R8 mode sweep
        do_reset();
        push(12);
        line_mode = 8'b10101010;
        full_pulse();
        for (int i = 0; i < W; i++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 16; s++) begin
                    @(negedge clk);
                    line_mode = 8'(m << (2 * i));
                    static_val = W'(s);
                    @(negedge clk);
                    chk("R8 oe", int'(pin_oe[i]), (m == 1 || m == 2) ? 1 : 0);
                    chk("R8 out", int'(pin_out[i]),
                        (m == 1) ? ((s >> i) & 1) : (m == 2) ? ((12 >> i) & 1) : 0);
                    chk("R8 other lines off", int'(pin_oe & ~(W'(1) << i)), 0);
                end
            end
        end

        // R9 input status
        for (int v = 0; v < 16; v++) begin
            @(negedge clk) pin_in = W'(v);
            @(negedge clk);
            chk("R9 pin_in_q", int'(pin_in_q), v);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule